// File: doc/BRIEF.md
# Serial Byte Receiver with Index/Data Tagging

This block receives a write-only serial stream for a display controller. A host drives a serial clock, a serial data line and a register-select line, and frames the transfer with two chip-select pins, one active-low and one active-high. The block counts rising edges of the serial clock and takes in one bit on each, most significant bit first. On every eighth edge it turns the collected bits into a parallel byte.

The register-select line is looked at only on that eighth edge. A low level marks the byte as an index, which is a register address. A high level marks it as display data or a command. The result leaves the block as a single system-clock strobe together with the byte and its tag.

All serial inputs are brought into the system clock domain by two-flop synchronizers. Serial clock edges are found in that domain, so the serial clock must run well below half the system clock rate. Whenever the block is not selected, or the mode input chooses the parallel bus, the bit counter and the shift register are held clear. Any partly received word is then lost.

Top module: `ser_byte_rx`

## Requirements
- R1: The receiver accepts bits only while `cs_n` is 0, `cs` is 1 and `ser_mode` is 1. In any other state, activity on `sclk` and `sdi` produces no `rx_valid`.
- R2: A bit is taken from `sdi` on each rising edge of `sclk`. The first bit of a word lands in `rx_data[7]` and the eighth in `rx_data[0]`.
- R3: On the eighth rising `sclk` edge of a word, `rx_valid` is 1 for exactly one system clock. At that time `rx_data` holds the assembled byte.
- R4: `rs` is sampled on the eighth rising `sclk` edge only. `rx_index` is 1 when that sample is 0 (index byte) and 0 when it is 1 (data or command byte). `rs` levels during the earlier seven edges have no effect.
- R5: Deselecting the block clears the bit counter and the shift register. A partly received word is discarded, and after reselection the next eight edges form a complete new byte.
- R6: The bit counter wraps to zero after the eighth bit, so words may follow one another with no gap between them.
- R7: While `ser_mode` is 0 the receiver is held cleared. After a return to serial mode, the next eight edges form a complete byte.
- R8: After reset, `rx_valid`, `rx_data` and `rx_index` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_mode | input | 1 | 1 selects serial mode, 0 selects parallel mode (receiver held cleared) |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| sdi | input | 1 | Serial data, most significant bit first |
| rs | input | 1 | Register select, sampled on the eighth `sclk` rise |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| rx_index | output | 1 | 1 when the byte is an index, 0 when it is data or a command |

## Verification
Several bytes are sent: alternating bits, all zeros, all ones and asymmetric values. These show whether bit order and shift direction are right, and whether a bit is stuck or swapped. In some bytes `rs` is held opposite to its final level for the first seven bits, which tells a tag taken on the eighth edge apart from one taken earlier. Other patterns are aimed at the clearing rules: back-to-back words with no gap, three bits followed by a deselect through either chip-select pin, a full byte clocked while deselected, and a byte clocked in parallel mode. Each of these exposes a counter that wraps wrongly or was not cleared, because any leftover count would emit a misaligned byte.

// File: rtl/ser_rx_pkg.sv
// Package: shared widths and the received-word type for the serial byte receiver.
package ser_rx_pkg;
    localparam int WORD_W = 8;
    localparam int CNT_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              is_index;
    } rx_word_t;
endpackage

// File: rtl/ser_sync.sv
// Two-flop synchronizer for a bundle of asynchronous single-bit inputs.
// Assumes each bit is an independent level; no cross-bit coherence is promised.
module ser_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

    // R2: the second stage follows the first stage one cycle later.
    a_r2_sync_follow: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> q == $past(meta));
endmodule

// File: rtl/ser_rise_det.sv
// Rising-edge detector on a synchronized serial clock.
// Assumes the input is already in the clk domain and has a high time of at least one cycle.
module ser_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_d;

    // Keep the previous level to compare against.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    // A rise is a high level that was low one cycle earlier.
    always_comb rise = lvl & ~lvl_d;

    // R2: a single serial clock rise is reported for one cycle only.
    a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/ser_word_shift.sv
// Bit counter and MSB-first shift register that assemble a word and tag it.
// Assumes one bit per 'rise' pulse; 'active' low clears the counter and the shift register.
module ser_word_shift
    import ser_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     active,
    input  logic     rise,
    input  logic     bit_in,
    input  logic     rs_in,
    output logic     word_vld,
    output rx_word_t word
);
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-2:0] shreg;
    logic              last_bit;

    always_comb last_bit = (cnt == CNT_W'(WORD_W - 1));

    // Counter and shift register: cleared while inactive, advanced on each rise.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (rise) begin
            cnt   <= last_bit ? '0 : cnt + 1'b1;
            shreg <= {shreg[WORD_W-3:0], bit_in};
        end
    end

    // Output register: latch byte and tag on the word's final rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            word_vld <= 1'b0;
            if (active && rise && last_bit) begin
                word_vld      <= 1'b1;
                word.data     <= {shreg, bit_in};
                word.is_index <= ~rs_in;
            end
        end
    end

    // R3: the valid strobe lasts one cycle.
    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
    // R6: the counter is back at zero whenever a byte is delivered.
    a_r6_wrap_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> cnt == '0);
    // R5: deselection leaves the counter cleared and emits nothing.
    a_r5_clear_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == '0) && !word_vld);
    // R4: the tag is the inverse of rs seen on the final rise.
    a_r4_tag_last_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rise && last_bit) |=> word_vld && (word.is_index == !$past(rs_in)));
    // R2: one bit shifts in per rise.
    a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rise) |=> shreg[0] == $past(bit_in));
endmodule

// File: rtl/ser_byte_rx.sv
// Top: serial byte receiver with dual chip select and index/data tagging.
// Assumes sclk runs well below half the clk rate; all serial inputs are asynchronous.
module ser_byte_rx
    import ser_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_mode,
    input  logic              cs_n,
    input  logic              cs,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              rs,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_index
);
    localparam int NSYNC = 6;

    logic [NSYNC-1:0] raw, syn;
    logic             s_mode, s_csn, s_cs, s_sclk, s_sdi, s_rs;
    logic             active, sclk_rise;
    rx_word_t         word;

    always_comb raw = {ser_mode, cs_n, cs, sclk, sdi, rs};

    ser_sync #(.W(NSYNC)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (syn)
    );

    always_comb {s_mode, s_csn, s_cs, s_sclk, s_sdi, s_rs} = syn;

    // Receiver is enabled only in serial mode with both selects asserted.
    always_comb active = s_mode & ~s_csn & s_cs;

    ser_rise_det i_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (s_sclk),
        .rise  (sclk_rise)
    );

    ser_word_shift i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .rise     (sclk_rise),
        .bit_in   (s_sdi),
        .rs_in    (s_rs),
        .word_vld (rx_valid),
        .word     (word)
    );

    always_comb begin
        rx_data  = word.data;
        rx_index = word.is_index;
    end

    // R1: no byte appears while the synchronized select state is inactive.
    a_r1_select_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !rx_valid);
endmodule

// File: tb/test_ser_byte_rx.sv
// Scoreboard bench: the driver queues expected bytes, the monitor compares them.
module test_ser_byte_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_mode = 1'b1, cs_n = 1'b1, cs = 1'b0;
    logic       sclk = 1'b0, sdi = 1'b0, rs = 1'b0;
    logic       rx_valid, rx_index;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    int got = 0;
    int sent = 0;
    logic [8:0] exp_q[$];

    always #5 clk = ~clk;

    ser_byte_rx i_ser_byte_rx (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .cs_n(cs_n), .cs(cs),
        .sclk(sclk), .sdi(sdi), .rs(rs),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_index(rx_index)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit: set data while sclk is low, then raise and lower sclk.
    task automatic send_bit(input logic b, input logic r);
        sdi = b; rs = r;
        wait_clk(4); sclk = 1'b1;
        wait_clk(4); sclk = 1'b0;
    endtask

    // Full word; rs_early drives the first seven bits, rs_last the eighth (R4).
    task automatic send_byte(input logic [7:0] v, input logic rs_last,
                             input logic rs_early, input logic expect_out);
        if (expect_out) begin
            exp_q.push_back({v, ~rs_last});
            sent++;
        end
        for (int i = 7; i >= 0; i--) send_bit(v[i], (i == 0) ? rs_last : rs_early);
    endtask

    // Monitor: pop and compare each delivered byte (R2, R3, R4).
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            logic [8:0] e;
            got++;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1/R5/R7 unexpected byte: actual %h/%0b expected none", rx_data, rx_index);
            end else begin
                e = exp_q.pop_front();
                if ({rx_data, rx_index} !== e) begin
                    errors++;
                    $display("FAIL R2/R3/R4 byte: actual %h idx %0b expected %h idx %0b",
                             rx_data, rx_index, e[8:1], e[0]);
                end
            end
        end
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        wait_clk(200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(4);
        // R8: reset state.
        checks++;
        if (rx_valid !== 1'b0 || rx_data !== 8'h00 || rx_index !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset: actual %0b %h %0b expected 0 00 0", rx_valid, rx_data, rx_index);
        end
        rst_n = 1'b1;
        wait_clk(2);
        cs_n = 1'b0; cs = 1'b1;
        wait_clk(4);

        // R2 R3 R4: distinct patterns, both tags.
        send_byte(8'hA5, 1'b1, 1'b1, 1'b1);
        send_byte(8'h3C, 1'b0, 1'b0, 1'b1);
        send_byte(8'h00, 1'b1, 1'b1, 1'b1);
        send_byte(8'hFF, 1'b0, 1'b0, 1'b1);
        // R4: rs opposite during the first seven bits.
        send_byte(8'h81, 1'b0, 1'b1, 1'b1);
        send_byte(8'h7E, 1'b1, 1'b0, 1'b1);
        // R6: back-to-back words with no gap.
        send_byte(8'h12, 1'b1, 1'b1, 1'b1);
        send_byte(8'hED, 1'b0, 1'b0, 1'b1);

        // R5: partial word then deselect by cs_n.
        send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b1); send_bit(1'b1, 1'b1);
        cs_n = 1'b1; wait_clk(8);
        // R1: full byte clocked while deselected must be ignored.
        send_byte(8'hF0, 1'b1, 1'b1, 1'b0);
        cs_n = 1'b0; wait_clk(8);
        send_byte(8'h5A, 1'b1, 1'b1, 1'b1);

        // R5: partial word then deselect by cs.
        send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
        cs = 1'b0; wait_clk(8);
        send_byte(8'h0F, 1'b0, 1'b0, 1'b0);
        cs = 1'b1; wait_clk(8);
        send_byte(8'h96, 1'b0, 1'b0, 1'b1);

        // R7: parallel mode holds the receiver cleared.
        send_bit(1'b0, 1'b1); send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b1);
        ser_mode = 1'b0; wait_clk(8);
        send_byte(8'hCC, 1'b1, 1'b1, 1'b0);
        send_bit(1'b1, 1'b1);
        ser_mode = 1'b1; wait_clk(8);
        send_byte(8'hC3, 1'b1, 1'b1, 1'b1);

        wait_clk(20);
        // R1 R5 R7: every expected byte arrived and nothing extra.
        checks++;
        if (got != sent || exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1/R5/R7 count: actual %0d bytes expected %0d", got, sent);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule